// File: doc/BRIEF.md
# Vector unsigned shift-right-accumulate unit

This unit takes a 128-bit source vector and a 128-bit accumulator vector, together with a two-part immediate. From the immediate it works out an element width and a right-shift amount. It then shifts every source lane logically right by that amount and adds the result into the matching accumulator lane. Lane sums wrap within their own width.

A control bit selects how much of the vector is processed. With the bit set, all 128 bits are processed. With the bit clear, only the low 64 bits are processed and the upper half of the result is zero. Some immediate patterns are not valid for this operation. For those, the unit raises an undefined flag instead of producing a sum.

A caller pulses `start` with the operands present. One cycle later the unit presents the result with a single-cycle `valid`. The result register keeps its value until the next `start`.

Top module: `lane_shra_accum`

## Requirements
- R1: While reset is held and after it is released with no start, `valid` and `undef` are 0 and `result` is all zeros.
- R2: `valid` is 1 in exactly the cycle after a cycle in which `start` was 1, and 0 in every other cycle.
- R3: When `imm_hi` equals 4'b0000, `undef` is 1 together with `valid` and `result` is all zeros.
- R4: When `imm_hi[3]` is 1 and `q_wide` is 0, `undef` is 1 together with `valid` and `result` is all zeros. For every accepted encoding, `undef` is 0 with `valid`.
- R5: The lane width is set by the highest set bit of `imm_hi`: bit 0 gives 8, bit 1 gives 16, bit 2 gives 32 and bit 3 gives 64 bits.
- R6: The shift equals twice the lane width minus the unsigned 7-bit value {imm_hi, imm_lo}. Each source lane is shifted right logically, with zeros entering from the top.
- R7: Each shifted lane is added to the matching accumulator lane modulo 2^width. No carry crosses a lane boundary.
- R8: When `q_wide` is 0, only bits 63:0 of both operands affect the result, and `result[127:64]` is zero.
- R9: When the shift equals the lane width, each result lane equals the accumulator lane unchanged.
- R10: In cycles without `start`, `result` keeps its previous value whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch one operation with the current operands |
| q_wide | input | 1 | 1: 128-bit operation; 0: 64-bit operation, upper half zeroed |
| imm_hi | input | 4 | Upper immediate field; its highest set bit picks the lane width |
| imm_lo | input | 3 | Lower immediate field |
| src_vec | input | 128 | Vector whose lanes are shifted |
| acc_vec | input | 128 | Vector the shifted lanes are added into |
| result | output | 128 | Registered accumulate result |
| valid | output | 1 | One-cycle pulse marking a new result |
| undef | output | 1 | Encoding rejected; meaningful when valid is 1 |

## Verification
Two cases are hard to reach by chance from the ports. The first is a rejected 64-bit-lane encoding with a narrow operation, where stale upper-half data must be discarded. The second is a shift of exactly one full lane width, which happens only at the lowest immediate value of each lane width. The stimulus sweeps every combination of `imm_hi`, `imm_lo` and `q_wide`. Each combination is run with all-ones operands to force wraparound in every lane, and with scrambled operands whose upper halves are non-zero. This drives both boundaries in every lane width.

// File: rtl/shra_pkg.sv
package shra_pkg;

    localparam int VEC_W    = 128;
    localparam int HALF_W   = VEC_W / 2;
    localparam int IMM_HI_W = 4;
    localparam int IMM_LO_W = 3;
    localparam int IMM_W    = IMM_HI_W + IMM_LO_W;
    localparam int SHIFT_W  = IMM_W;
    localparam int N_SIZES  = 4;
    localparam int MIN_LANE = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } elem_size_e;

    typedef struct packed {
        logic               reject;
        elem_size_e         size;
        logic [SHIFT_W-1:0] shamt;
    } imm_decode_t;

    typedef struct packed {
        logic             fault;
        logic [VEC_W-1:0] data;
    } shra_result_t;

    // Highest set bit of the upper immediate selects the lane width.
    function automatic elem_size_e top_bit_size(input logic [IMM_HI_W-1:0] hi);
        elem_size_e s;
        casez (hi)
            4'b1???: s = SZ_DBL;
            4'b01??: s = SZ_WORD;
            4'b001?: s = SZ_HALF;
            default: s = SZ_BYTE;
        endcase
        return s;
    endfunction

    // Twice the lane width, taken modulo 2^SHIFT_W; the 64-bit case wraps
    // to zero, which keeps the subtraction below correct in 7 bits.
    function automatic logic [SHIFT_W-1:0] double_width(input elem_size_e s);
        logic [SHIFT_W:0] full;
        full = (SHIFT_W+1)'(2 * MIN_LANE) << s;
        return full[SHIFT_W-1:0];
    endfunction

endpackage

// File: rtl/shra_imm_decode.sv
module shra_imm_decode
    import shra_pkg::*;
(
    input  logic [IMM_HI_W-1:0] imm_hi,
    input  logic [IMM_LO_W-1:0] imm_lo,
    input  logic                q_wide,
    output imm_decode_t         dec
);

    logic [IMM_W-1:0] imm_full;
    logic             no_bits;
    logic             wide_only;

    assign imm_full  = {imm_hi, imm_lo};
    assign no_bits   = (imm_hi == '0);
    assign wide_only = imm_hi[IMM_HI_W-1] & ~q_wide;

    always_comb begin
        dec.size   = top_bit_size(imm_hi);
        dec.shamt  = double_width(dec.size) - imm_full;
        dec.reject = no_bits | wide_only;
    end

endmodule

// File: rtl/shra_lane_bank.sv
module shra_lane_bank
    import shra_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int DATA_W = VEC_W
)(
    input  logic [DATA_W-1:0]  src_vec,
    input  logic [DATA_W-1:0]  acc_vec,
    input  logic [SHIFT_W-1:0] shamt,
    output logic [DATA_W-1:0]  sum_vec
);

    localparam int N_LANES = DATA_W / LANE_W;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic [LANE_W-1:0] src_l;
        logic [LANE_W-1:0] acc_l;
        logic [LANE_W-1:0] shr_l;

        assign src_l = src_vec[i*LANE_W +: LANE_W];
        assign acc_l = acc_vec[i*LANE_W +: LANE_W];
        // A shift of LANE_W or more drains the lane to zero.
        assign shr_l = src_l >> shamt;
        assign sum_vec[i*LANE_W +: LANE_W] = acc_l + shr_l;
    end

endmodule

// File: rtl/shra_size_select.sv
module shra_size_select
    import shra_pkg::*;
(
    input  logic [N_SIZES-1:0][VEC_W-1:0] cand,
    input  imm_decode_t                   dec,
    input  logic                          q_wide,
    output shra_result_t                  res
);

    logic [VEC_W-1:0] picked;

    always_comb begin
        picked    = cand[dec.size];
        res.fault = dec.reject;
        if (dec.reject)
            res.data = '0;
        else if (!q_wide)
            res.data = {{(VEC_W-HALF_W){1'b0}}, picked[HALF_W-1:0]};
        else
            res.data = picked;
    end

endmodule

// File: rtl/lane_shra_accum.sv
module lane_shra_accum
    import shra_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                q_wide,
    input  logic [IMM_HI_W-1:0] imm_hi,
    input  logic [IMM_LO_W-1:0] imm_lo,
    input  logic [VEC_W-1:0]    src_vec,
    input  logic [VEC_W-1:0]    acc_vec,
    output logic [VEC_W-1:0]    result,
    output logic                valid,
    output logic                undef
);

    imm_decode_t                   dec;
    logic [N_SIZES-1:0][VEC_W-1:0] cand;
    shra_result_t                  nxt;

    shra_imm_decode u_decode (
        .imm_hi (imm_hi),
        .imm_lo (imm_lo),
        .q_wide (q_wide),
        .dec    (dec)
    );

    for (genvar k = 0; k < N_SIZES; k++) begin : g_size
        shra_lane_bank #(
            .LANE_W (MIN_LANE << k),
            .DATA_W (VEC_W)
        ) u_bank (
            .src_vec (src_vec),
            .acc_vec (acc_vec),
            .shamt   (dec.shamt),
            .sum_vec (cand[k])
        );
    end

    shra_size_select u_select (
        .cand   (cand),
        .dec    (dec),
        .q_wide (q_wide),
        .res    (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            valid  <= 1'b0;
            undef  <= 1'b0;
        end else begin
            valid <= start;
            undef <= start & nxt.fault;
            if (start)
                result <= nxt.data;
        end
    end

endmodule

// File: rtl/lane_shra_accum_chk.sv
module lane_shra_accum_chk
    import shra_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                q_wide,
    input logic [IMM_HI_W-1:0] imm_hi,
    input logic [VEC_W-1:0]    result,
    input logic                valid,
    input logic                undef
);

    a_r2_valid_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> valid);

    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !start |=> !valid);

    a_r3_empty_imm_rejected: assert property (@(posedge clk) disable iff (rst)
        (start && imm_hi == '0) |=> (undef && result == '0));

    a_r4_wide_lane_narrow_op: assert property (@(posedge clk) disable iff (rst)
        (start && imm_hi[IMM_HI_W-1] && !q_wide) |=> (undef && result == '0));

    a_r4_undef_only_with_valid: assert property (@(posedge clk) disable iff (rst)
        undef |-> valid);

    a_r8_upper_half_zero: assert property (@(posedge clk) disable iff (rst)
        (start && !q_wide) |=> (result[VEC_W-1:HALF_W] == '0));

    a_r10_result_holds: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(result));

endmodule

bind lane_shra_accum lane_shra_accum_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .q_wide (q_wide),
    .imm_hi (imm_hi),
    .result (result),
    .valid  (valid),
    .undef  (undef)
);

// File: tb/lane_shra_accum_tb.sv
module lane_shra_accum_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         q_wide = 1'b0;
    logic [3:0]   imm_hi = '0;
    logic [2:0]   imm_lo = '0;
    logic [127:0] src_vec = '0;
    logic [127:0] acc_vec = '0;
    logic [127:0] result;
    logic         valid;
    logic         undef;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_shra_accum u_dut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .q_wide  (q_wide),
        .imm_hi  (imm_hi),
        .imm_lo  (imm_lo),
        .src_vec (src_vec),
        .acc_vec (acc_vec),
        .result  (result),
        .valid   (valid),
        .undef   (undef)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Arithmetic reference: lane width from highest set bit (R5), shift
    // 2*width minus the immediate (R6), lane-wise wrap add (R7), narrow
    // form zeroes the top half (R8), rejected encodings give zero (R3, R4).
    function automatic logic [128:0] model(input logic [3:0] hi, input logic [2:0] lo,
                                           input logic q, input logic [127:0] s,
                                           input logic [127:0] a);
        int es, sh;
        logic [127:0] mask, r, ls, la;
        if (hi == 4'b0000 || (hi[3] && !q)) return {1'b1, 128'b0};
        es = hi[3] ? 64 : hi[2] ? 32 : hi[1] ? 16 : 8;
        sh = 2*es - int'({hi, lo});
        mask = {128{1'b1}} >> (128 - es);
        r = '0;
        for (int i = 0; i < 128/es; i++) begin
            ls = (s >> (i*es)) & mask;
            la = (a >> (i*es)) & mask;
            r  = r | ((((ls >> sh) + la) & mask) << (i*es));
        end
        if (!q) r[127:64] = '0;
        return {1'b0, r};
    endfunction

    task automatic run_vec(input logic [3:0] hi, input logic [2:0] lo, input logic q,
                           input logic [127:0] s, input logic [127:0] a);
        logic [128:0] exp;
        string tag;
        int es;
        exp = model(hi, lo, q, s, a);
        es  = hi[3] ? 64 : hi[2] ? 32 : hi[1] ? 16 : 8;
        if (hi == 4'b0000)                 tag = "R3";
        else if (hi[3] && !q)              tag = "R4";
        else if (int'({hi, lo}) == es)     tag = "R9";
        else if (!q)                       tag = "R8";
        else                               tag = "R5/R6/R7";
        @(negedge clk);
        imm_hi = hi; imm_lo = lo; q_wide = q; src_vec = s; acc_vec = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(valid === 1'b1 && undef === exp[128] && result === exp[127:0],
              {tag, " vector"}, {valid, undef, result[125:0]},
              {1'b1, exp[128], exp[125:0]});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset
        check(valid === 1'b0 && undef === 1'b0 && result === '0, "R1 in reset",
              {valid, undef, result[125:0]}, '0);
        rst = 1'b0;
        @(negedge clk);
        check(valid === 1'b0 && undef === 1'b0 && result === '0, "R1 after release",
              {valid, undef, result[125:0]}, '0);

        // R9 direct: shift equal to lane width keeps the accumulator
        run_vec(4'b0001, 3'b000, 1'b1, {128{1'b1}}, 128'h0123456789abcdef_fedcba9876543210);
        // R7 direct: all-ones wraps in each byte with no carry out
        run_vec(4'b0001, 3'b111, 1'b1, {128{1'b1}}, {128{1'b1}});

        // R2 / R10: no start -> no valid, result held despite new inputs
        begin
            logic [127:0] held;
            held = result;
            @(negedge clk);
            src_vec = ~src_vec; acc_vec = 128'h5; imm_hi = 4'b0100;
            @(negedge clk);
            check(valid === 1'b0, "R2 no start no valid", {127'b0, valid}, '0);
            check(result === held, "R10 result held", result, held);
        end

        // Exhaustive sweep of immediate and width selection
        for (int h = 0; h < 16; h++)
            for (int l = 0; l < 8; l++)
                for (int qq = 0; qq < 2; qq++) begin
                    run_vec(4'(h), 3'(l), 1'(qq), {128{1'b1}}, {128{1'b1}});
                    run_vec(4'(h), 3'(l), 1'(qq),
                            {$urandom, $urandom, $urandom, $urandom},
                            {$urandom, $urandom, $urandom, $urandom});
                    run_vec(4'(h), 3'(l), 1'(qq),
                            {4{32'h8000_0001}}, {4{32'h7fff_ffff}});
                end

        // R2: valid drops the cycle after its pulse
        @(negedge clk);
        check(valid === 1'b0, "R2 pulse ends", {127'b0, valid}, '0);

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule